// File: doc/BRIEF.md
# AES Round-Step Vector Execution Unit

This unit executes single steps of the AES cipher for a 128-bit vector pipeline. Each cycle it may accept an instruction word and two 128-bit operands. The operands are the current value of the destination register and the value of the source register. It decodes one of four fixed instruction patterns and computes the 128-bit value to be written back to the destination register. The forward step applies the round key and then the forward byte substitution and row rotation. The backward step does the same with the inverse substitution and inverse row rotation. The two column-mixing instructions apply the forward or inverse column transform to the source operand alone.

The state is laid out in the register with byte i in bits [8i+7:8i]. Column c holds bytes 4c..4c+3, and row r of that column is byte 4c+r. The result, the destination index and an illegal-instruction flag are registered, so they appear one clock after the input strobe. Key expansion, round sequencing and the register file are left to the surrounding pipeline.

Top module: `aes_step_unit`

## Requirements
- R1: An instruction is legal only when (instr_i & 0xFFFFCC00) == 0x4E284800. Bits [13:12] then select the operation: 0 is the forward step, 1 the backward step, 2 forward mix, 3 inverse mix.
- R2: The forward step returns SubBytes(ShiftRows(vd_i ^ vn_i)). ShiftRows moves the byte at row r, column c to column (c-r) mod 4 of the same row. When the XOR is all zero, every result byte is 0x63.
- R3: The backward step returns InvSubBytes(InvShiftRows(vd_i ^ vn_i)). InvShiftRows moves the byte at row r, column c to column (c+r) mod 4. When the XOR is all zero, every result byte is 0x52.
- R4: Forward mix returns MixColumns(vn_i). For output row r, the coefficients (02,03,01,01) are rotated right by r. The value of vd_i has no effect on the result.
- R5: Inverse mix returns InvMixColumns(vn_i) with coefficients (0E,0B,0D,09) rotated right by r. The value of vd_i has no effect on the result.
- R6: Column c occupies result bits [32c+31:32c], with row 0 in the least significant byte. The column transform acts on each column independently.
- R7: rd_o equals instr_i[4:0] of the accepted instruction.
- R8: An illegal instruction with valid_i high gives illegal_o=1 and valid_o=0 in the next cycle, and result_o keeps its previous value.
- R9: The outputs for an instruction appear exactly one clock after valid_i. A cycle without valid_i gives valid_o=0 and illegal_o=0 in the next cycle. Back-to-back instructions are accepted every cycle.
- R10: After reset, valid_o, illegal_o, result_o and rd_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands present |
| instr_i | input | 32 | Instruction word |
| vd_i | input | 128 | Current destination register value |
| vn_i | input | 128 | Source register value |
| valid_o | output | 1 | Result valid for a legal instruction |
| illegal_o | output | 1 | Accepted instruction matched no pattern |
| result_o | output | 128 | Value to write to the destination register |
| rd_o | output | 5 | Destination register index |

## Verification
The forward and backward steps are tried with known round vectors. The destination and source operands are each split by a nonzero key, so a design that ignores one operand gives a wrong result. The all-zero XOR separates the two S-box constants. A lone nonzero byte in row 1 shows the direction of the row rotation, since each direction puts the byte in a different output byte. The column transforms are tried with a full vector and with a single nonzero column placed at column 0 and at column 2, which exposes byte-order and column-placement errors. Illegal patterns that differ from a legal one in a single fixed bit, and back-to-back issue, check the decode and the one-cycle timing.

// File: rtl/aes_step_pkg.sv
package aes_step_pkg;
  localparam int DATA_W  = 128;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int NBYTES  = DATA_W / 8;
  localparam int NCOLS   = NBYTES / 4;

  localparam logic [INSTR_W-1:0] ENC_MASK = 32'hFFFF_CC00;
  localparam logic [INSTR_W-1:0] ENC_BASE = 32'h4E28_4800;

  typedef enum logic [1:0] {
    OP_FWD  = 2'd0,
    OP_BWD  = 2'd1,
    OP_MIX  = 2'd2,
    OP_IMIX = 2'd3
  } step_op_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // a^254 is the field inverse, 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sub_fwd(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sub_inv(input logic [7:0] a);
    return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction
endpackage

// File: rtl/aes_step_sbox.sv
module aes_step_sbox #(
  parameter bit INV = 1'b0
) (
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);
  import aes_step_pkg::*;

  generate
    if (INV) begin : g_inv
      assign out_o = sub_inv(in_i);
    end else begin : g_fwd
      assign out_o = sub_fwd(in_i);
    end
  endgenerate
endmodule

// File: rtl/aes_step_mixcol.sv
module aes_step_mixcol #(
  parameter bit INV = 1'b0
) (
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  import aes_step_pkg::*;

  localparam logic [31:0] COEF = INV ? 32'h090D0B0E : 32'h01010302; // byte k = coefficient k

  always_comb begin
    col_o = '0;
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) begin
        col_o[8*r +: 8] = col_o[8*r +: 8] ^
          gf_mul(COEF[8*((k - r + 4) % 4) +: 8], col_i[8*k +: 8]);
      end
    end
  end
endmodule

// File: rtl/aes_step_decode.sv
module aes_step_decode
  import aes_step_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic               legal_o,
  output step_op_e           op_o,
  output logic [IDX_W-1:0]   rd_o
);
  assign legal_o = (instr_i & ENC_MASK) == ENC_BASE;
  assign op_o    = step_op_e'(instr_i[13:12]);
  assign rd_o    = instr_i[IDX_W-1:0];
endmodule

// File: rtl/aes_step_unit.sv
module aes_step_unit
  import aes_step_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [31:0]        instr_i,
  input  logic [127:0]       vd_i,
  input  logic [127:0]       vn_i,
  output logic               valid_o,
  output logic               illegal_o,
  output logic [127:0]       result_o,
  output logic [4:0]         rd_o
);
  logic              legal;
  step_op_e          op;
  logic [IDX_W-1:0]  rd_d;
  logic [DATA_W-1:0] keyed, shr_fwd, shr_inv, sub_f, sub_i, mix_f, mix_i, res_d;

  aes_step_decode i_dec (
    .instr_i(instr_i),
    .legal_o(legal),
    .op_o   (op),
    .rd_o   (rd_d)
  );

  assign keyed = vd_i ^ vn_i;

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      // output (r,c) takes input (r,c+r) forward, (r,c-r) inverse
      assign shr_fwd[8*(4*c+r) +: 8] = keyed[8*(4*((c + r) % 4) + r) +: 8];
      assign shr_inv[8*(4*c+r) +: 8] = keyed[8*(4*((c + 4 - r) % 4) + r) +: 8];

      aes_step_sbox #(.INV(1'b0)) i_sbf (.in_i(shr_fwd[8*(4*c+r) +: 8]), .out_o(sub_f[8*(4*c+r) +: 8]));
      aes_step_sbox #(.INV(1'b1)) i_sbi (.in_i(shr_inv[8*(4*c+r) +: 8]), .out_o(sub_i[8*(4*c+r) +: 8]));
    end

    aes_step_mixcol #(.INV(1'b0)) i_mcf (.col_i(vn_i[32*c +: 32]), .col_o(mix_f[32*c +: 32]));
    aes_step_mixcol #(.INV(1'b1)) i_mci (.col_i(vn_i[32*c +: 32]), .col_o(mix_i[32*c +: 32]));
  end

  always_comb begin
    unique case (op)
      OP_FWD:  res_d = sub_f;
      OP_BWD:  res_d = sub_i;
      OP_MIX:  res_d = mix_f;
      default: res_d = mix_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      rd_o      <= '0;
    end else begin
      valid_o   <= valid_i & legal;
      illegal_o <= valid_i & ~legal;
      if (valid_i) rd_o <= rd_d;
      if (valid_i && legal) result_o <= res_d;
    end
  end

  assert_status_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o));

  assert_illegal_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(result_o));

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o || illegal_o));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !illegal_o));

  assert_rd_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (rd_o == $past(instr_i[4:0])));
endmodule

// File: tb/test_aes_step_unit.sv
module test_aes_step_unit;
  localparam int NV = 9;
  localparam logic [127:0] PT  = {64'h7B5B546573745665, 64'h63746F725D53475D};
  localparam logic [127:0] KEY = {64'h0123456789ABCDEF, 64'hFEDCBA9876543210};

  localparam logic [31:0] V_INS [NV] = '{
    32'h4E284820, // R2 known vector
    32'h4E285823, // R3 known vector
    32'h4E2868A5, // R4 known vector, vd all ones
    32'h4E28783F, // R5 known vector
    32'h4E284807, // R2 zero state
    32'h4E285800, // R3 zero state
    32'h4E284802, // R2 row-1 byte direction
    32'h4E285804, // R3 row-1 byte direction
    32'h4E287802  // R5 single column
  };
  localparam logic [127:0] V_VD [NV] = '{
    PT ^ KEY,
    PT ^ KEY,
    {128{1'b1}},
    128'h0,
    {16{8'h5A}},
    128'h0,
    128'h5300,
    128'h6300,
    {16{8'hC3}}
  };
  localparam logic [127:0] V_VN [NV] = '{
    KEY,
    KEY,
    {64'h627A6F6644B109C8, 64'h2B18330A81C3B3E5},
    {64'h8DCAB9DC035006BC, 64'h8F57161E00CAFD8D},
    {16{8'h5A}},
    128'h0,
    128'h0,
    128'h0,
    {96'h0, 32'hBCA14D8E}
  };
  localparam logic [127:0] V_EXP [NV] = '{
    {64'h8F92A04DFBED204D, 64'h4C39B1402192A84C},
    {64'h8DCAB9BC035006BC, 64'h8F57161E00CAFD8D},
    PT,
    {64'hD635A667928B5EAE, 64'hEEC9CC3BC55F5777},
    {16{8'h63}},
    {16{8'h52}},
    128'h6363ED63_63636363_63636363_63636363,
    {64'h5252525252525252, 64'h5252005252525252},
    {96'h0, 32'h455313DB}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] vd = '0, vn = '0;
  logic         valid_out, illegal_out;
  logic [127:0] result;
  logic [4:0]   rd;
  int           n_chk = 0, n_bad = 0;
  logic [127:0] held;

  always #10 clk = ~clk;

  aes_step_unit i_aes_step_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .instr_i(instr),
    .vd_i(vd), .vn_i(vn), .valid_o(valid_out), .illegal_o(illegal_out),
    .result_o(result), .rd_o(rd)
  );

  function automatic string op_tag(input logic [31:0] w);
    case (w[13:12])
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [127:0] d, input logic [127:0] n);
    valid_in = 1'b1; instr = w; vd = d; vn = n;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", {127'h0, valid_out}, 128'h0);
    chk("R10 illegal", {127'h0, illegal_out}, 128'h0);
    chk("R10 result", result, 128'h0);
    chk("R10 rd", {123'h0, rd}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle valid", {127'h0, valid_out}, 128'h0);

    for (int i = 0; i < NV; i++) begin
      drive(V_INS[i], V_VD[i], V_VN[i]);
      @(negedge clk);
      valid_in = 1'b0;
      chk(op_tag(V_INS[i]), result, V_EXP[i]);
      chk("R9 valid", {127'h0, valid_out}, 128'h1);
      chk("R7 rd", {123'h0, rd}, {123'h0, V_INS[i][4:0]});
    end

    // R6 column placement: column 2 alone
    drive(32'h4E286801, 128'h0, {32'h0, 32'h455313DB, 64'h0});
    @(negedge clk);
    valid_in = 1'b0;
    chk("R6 column 2", result, {32'h0, 32'hBCA14D8E, 64'h0});

    // R4 vd has no effect: same vn, different vd
    drive(32'h4E286801, {16{8'hA5}}, {32'h0, 32'h455313DB, 64'h0});
    @(negedge clk);
    valid_in = 1'b0;
    chk("R4 vd ignored", result, {32'h0, 32'hBCA14D8E, 64'h0});
    held = result;

    // R9 idle cycle
    @(negedge clk);
    chk("R9 idle valid", {127'h0, valid_out}, 128'h0);
    chk("R9 idle illegal", {127'h0, illegal_out}, 128'h0);

    // R1/R8 illegal: bit 10 set
    drive(32'h4E284C00, 128'h1, 128'h2);
    @(negedge clk);
    valid_in = 1'b0;
    chk("R8 illegal flag", {127'h0, illegal_out}, 128'h1);
    chk("R8 valid low", {127'h0, valid_out}, 128'h0);
    chk("R8 result held", result, held);

    // R1 illegal: bit 30 cleared
    drive(32'h0E284800, 128'h0, 128'h0);
    @(negedge clk);
    valid_in = 1'b0;
    chk("R1 bit30 illegal", {127'h0, illegal_out}, 128'h1);
    chk("R1 result held", result, held);

    // R9 back-to-back
    drive(32'h4E284809, 128'h0, 128'h0);
    @(negedge clk);
    chk("R9 b2b first", result, {16{8'h63}});
    chk("R9 b2b rd", {123'h0, rd}, 128'd9);
    drive(32'h4E28580A, 128'h0, 128'h0);
    @(negedge clk);
    valid_in = 1'b0;
    chk("R9 b2b second", result, {16{8'h52}});
    chk("R9 b2b valid", {127'h0, valid_out}, 128'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule